// File: doc/BRIEF.md
# I2C Controller Interrupt Register Bank

This block holds the interrupt state of an I2C controller that has twelve event sources. The controller core sends one-cycle event pulses. These pulses set sticky raw status bits. Two of the sources, receive-full and transmit-empty, are not sticky: they follow live FIFO level inputs instead. A mask register selects which raw bits reach the single level interrupt line. A masked status view gives software the raw bits with the mask applied.

Software clears interrupts through reads that have a side effect. Each source has its own clear register, and a read of it drops only that source's raw bit. A clear-all register drops every sticky bit at once. When a transmit abort happens, the core also pulses cause bits into an abort-cause register. Those bits build up until the abort interrupt is cleared, either through its own clear register or through the clear-all register. At that point the cause register is wiped, so software must read the causes first.

Register map by word address: 0 is raw status, 1 is the mask (the only writable register), 2 is masked status, 3 is abort causes, 4 is clear-all, and 8+i is the clear register of source i. Read data appears one cycle after the read strobe and reflects the state before any clear that the read causes.

Top module: `i2c_irq_bank`

## Requirements
- R1: Raw status bit order is rx_under=0, rx_over=1, rx_full=2, tx_over=3, tx_empty=4, rd_req=5, tx_abrt=6, rx_done=7, activity=8, stop_det=9, start_det=10, gen_call=11. An event pulse on a sticky source sets its raw bit, and the bit stays set. No raw bit rises without an event.
- R2: The mask resets to 0x254, which enables rx_full, tx_empty, tx_abrt and stop_det. Masked status (address 2) reads as raw AND mask.
- R3: A read of address 8+i clears raw bit i only, and returns that bit's pre-clear value in bit 0.
- R4: A read of address 4 clears all sticky raw bits and returns 0.
- R5: An event pulse in the same cycle as a read that clears the same bit wins, so the bit stays set.
- R6: Abort cause bits (address 3) accumulate by OR and are held until the abort interrupt is cleared. Their positions are: 7-bit address NACK=0, 10-bit first byte NACK=1, 10-bit second byte NACK=2, data NACK=3, general-call NACK=4, general-call read=5, start byte acked=7, start byte without restart=9, 10-bit read without restart=10, master disabled=11, arbitration lost=12.
- R7: A read of address 14 (the clear for tx_abrt) or of address 4 wipes the abort cause register.
- R8: Raw bits 2 and 4 follow the rx_full and tx_empty level inputs. Event pulses and clear reads on those bits have no effect.
- R9: irq_o is high exactly when some masked status bit is set.
- R10: Only a write to address 1 changes the mask. Writes to other addresses change no state. Read data is valid one cycle after rd_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_i | input | 12 | One-cycle event pulses, one per source |
| abrt_src_i | input | 13 | One-cycle abort cause pulses |
| rx_full_lvl_i | input | 1 | Live receive-threshold level |
| tx_empty_lvl_i | input | 1 | Live transmit-threshold level |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side-effect clears) |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | 12 | Write data (mask value) |
| rdata_o | output | DATA_W | Read data, one cycle after the strobe |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: a 5-bit address and a 16-bit read bus. At this size, every one of the twelve sources can be set and cleared on its own, both alone and against a background of all other bits. Every single-bit mask, plus the empty and full masks, is swept against a known raw pattern, with the expected masked value and interrupt computed in the bench. Each legal abort cause position is accumulated one at a time. Collisions between events and clears are driven in the exact cycle of the clearing read.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
    localparam int NUM_SRC = 12;
    localparam int ABRT_W  = 13;

    localparam int SRC_RX_UNDER  = 0;
    localparam int SRC_RX_OVER   = 1;
    localparam int SRC_RX_FULL   = 2;
    localparam int SRC_TX_OVER   = 3;
    localparam int SRC_TX_EMPTY  = 4;
    localparam int SRC_RD_REQ    = 5;
    localparam int SRC_TX_ABRT   = 6;
    localparam int SRC_RX_DONE   = 7;
    localparam int SRC_ACTIVITY  = 8;
    localparam int SRC_STOP_DET  = 9;
    localparam int SRC_START_DET = 10;
    localparam int SRC_GEN_CALL  = 11;

    localparam logic [NUM_SRC-1:0] LEVEL_SRCS =
        (NUM_SRC'(1) << SRC_RX_FULL) | (NUM_SRC'(1) << SRC_TX_EMPTY);
    localparam logic [NUM_SRC-1:0] STICKY_SRCS = ~LEVEL_SRCS;
    localparam logic [NUM_SRC-1:0] MASK_RESET =
        LEVEL_SRCS | (NUM_SRC'(1) << SRC_TX_ABRT) | (NUM_SRC'(1) << SRC_STOP_DET);

    localparam int REG_RAW      = 0;
    localparam int REG_MASK     = 1;
    localparam int REG_MSTAT    = 2;
    localparam int REG_CAUSE    = 3;
    localparam int REG_CLRALL   = 4;
    localparam int REG_CLR_BASE = 8;

    typedef struct packed {
        logic [NUM_SRC-1:0] raw;
        logic [ABRT_W-1:0]  cause;
    } irq_state_t;
endpackage

// File: rtl/i2c_irq_decode.sv
module i2c_irq_decode
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [NUM_SRC-1:0] clr_o
);
    logic hit_all;
    assign hit_all = rd_en_i && (addr_i == ADDR_W'(REG_CLRALL));

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_clr
        assign clr_o[g] = hit_all ||
                          (rd_en_i && (addr_i == ADDR_W'(REG_CLR_BASE + g)));
    end
endmodule

// File: rtl/i2c_irq_state.sv
module i2c_irq_state
    import i2c_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] ev_i,
    input  logic [NUM_SRC-1:0] clr_i,
    input  logic [ABRT_W-1:0]  abrt_src_i,
    output logic [NUM_SRC-1:0] raw_o,
    output logic [ABRT_W-1:0]  cause_o
);
    irq_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.raw = ((st_q.raw & ~clr_i) | ev_i) & STICKY_SRCS;
        if (clr_i[SRC_TX_ABRT]) begin
            st_d.cause = '0;
        end
        st_d.cause = st_d.cause | abrt_src_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o   = st_q.raw;
    assign cause_o = st_q.cause;

    AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_o & ~$past(raw_o) & ~$past(ev_i)) == '0)); // R1
    AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ev_i & STICKY_SRCS)) |=> ((raw_o & $past(ev_i & STICKY_SRCS)) == $past(ev_i & STICKY_SRCS))); // R5
    AST_CLEAR_TARGETED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(raw_o) & ~$past(clr_i) & ~raw_o) == '0)); // R3
    AST_CLEAR_ALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        ((&clr_i) && (ev_i == '0)) |=> (raw_o == '0)); // R4
    AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(clr_i[SRC_TX_ABRT]) || (($past(cause_o) & ~cause_o) == '0))); // R6
    AST_CAUSE_WIPED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[SRC_TX_ABRT] && (abrt_src_i == '0)) |=> (cause_o == '0)); // R7
endmodule

// File: rtl/i2c_irq_regif.sv
module i2c_irq_regif
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    input  logic [NUM_SRC-1:0] raw_view_i,
    input  logic [ABRT_W-1:0]  cause_i,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [DATA_W-1:0]  rdata_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic [DATA_W-1:0]  rdata;
    } regif_t;

    regif_t rg_d, rg_q;
    logic [DATA_W-1:0] rd_val;

    always_comb begin
        rd_val = '0;
        if (addr_i == ADDR_W'(REG_RAW))   rd_val = DATA_W'(raw_view_i);
        if (addr_i == ADDR_W'(REG_MASK))  rd_val = DATA_W'(rg_q.mask);
        if (addr_i == ADDR_W'(REG_MSTAT)) rd_val = DATA_W'(raw_view_i & rg_q.mask);
        if (addr_i == ADDR_W'(REG_CAUSE)) rd_val = DATA_W'(cause_i);
        for (int i = 0; i < NUM_SRC; i++) begin
            if (addr_i == ADDR_W'(REG_CLR_BASE + i)) rd_val = DATA_W'(raw_view_i[i]);
        end
    end

    always_comb begin
        rg_d       = rg_q;
        rg_d.rdata = rd_en_i ? rd_val : '0;
        if (wr_en_i && (addr_i == ADDR_W'(REG_MASK))) begin
            rg_d.mask = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rg_q.mask  <= MASK_RESET;
            rg_q.rdata <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign mask_o  = rg_q.mask;
    assign rdata_o = rg_q.rdata;

    AST_MSTAT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && (addr_i == ADDR_W'(REG_MSTAT))) |=>
        (rdata_o == DATA_W'($past(raw_view_i & mask_o)))); // R2
    AST_MASK_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && (addr_i == ADDR_W'(REG_MASK))) |=> $stable(mask_o)); // R10
endmodule

// File: rtl/i2c_irq_bank.sv
module i2c_irq_bank
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] ev_i,
    input  logic [ABRT_W-1:0]  abrt_src_i,
    input  logic               rx_full_lvl_i,
    input  logic               tx_empty_lvl_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] sticky_raw;
    logic [NUM_SRC-1:0] raw_view;
    logic [NUM_SRC-1:0] mask;
    logic [NUM_SRC-1:0] levels;
    logic [ABRT_W-1:0]  cause;

    i2c_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .rd_en_i (rd_en_i),
        .addr_i  (addr_i),
        .clr_o   (clr)
    );

    i2c_irq_state u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (ev_i),
        .clr_i      (clr),
        .abrt_src_i (abrt_src_i),
        .raw_o      (sticky_raw),
        .cause_o    (cause)
    );

    always_comb begin
        levels               = '0;
        levels[SRC_RX_FULL]  = rx_full_lvl_i;
        levels[SRC_TX_EMPTY] = tx_empty_lvl_i;
        raw_view             = (sticky_raw & STICKY_SRCS) | levels;
    end

    i2c_irq_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .rd_en_i    (rd_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .raw_view_i (raw_view),
        .cause_i    (cause),
        .mask_o     (mask),
        .rdata_o    (rdata_o)
    );

    assign irq_o = |(raw_view & mask);

    AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && (addr_i == ADDR_W'(REG_RAW))) |=>
        (rdata_o[SRC_RX_FULL] == $past(rx_full_lvl_i))); // R8
endmodule

// File: tb/i2c_irq_bank_test.sv
module i2c_irq_bank_test;
    localparam int CLK_T = 10;
    localparam int AW = 5;
    localparam int DW = 16;
    localparam logic [11:0] STICKY = 12'hFEB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [11:0] ev = '0;
    logic [12:0] abrt = '0;
    logic rxf = 1'b0, txe = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [11:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic irq;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #(CLK_T/2) clk = ~clk;

    i2c_irq_bank #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .ev_i(ev), .abrt_src_i(abrt),
        .rx_full_lvl_i(rxf), .tx_empty_lvl_i(txe), .wr_en_i(wr_en),
        .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [DW-1:0] d);
        @(negedge clk); rd_en = 1'b1; addr = AW'(a);
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic wr(input int a, input logic [11:0] v);
        @(negedge clk); wr_en = 1'b1; addr = AW'(a); wdata = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [11:0] e, input logic [12:0] c);
        @(negedge clk); ev = e; abrt = c;
        @(negedge clk); ev = '0; abrt = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic [12:0] acc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd(0, d); check("R1 reset raw", d, 0);
        rd(1, d); check("R2 reset mask", d, 16'h254);
        rd(3, d); check("R6 reset cause", d, 0);
        check("R9 reset irq", irq, 0);

        for (int i = 0; i < 12; i++) begin
            if (!STICKY[i]) continue;
            pulse(12'(1 << i), '0);
            rd(0, d); check("R1 single set", d, 32'(1 << i));
            rd(8 + i, d); check("R3 clear returns bit", d, 1);
            rd(0, d); check("R3 single cleared", d, 0);
            pulse(STICKY, '0);
            rd(8 + i, d);
            rd(0, d); check("R3 only target cleared", d, 32'(STICKY & ~(12'(1 << i))));
            rd(4, d); check("R4 clear-all returns 0", d, 0);
            rd(0, d); check("R4 all cleared", d, 0);
        end

        rxf = 1'b1;
        pulse(STICKY, '0);
        for (int m = 0; m < 14; m++) begin
            logic [11:0] mv;
            mv = (m < 12) ? 12'(1 << m) : ((m == 12) ? 12'h000 : 12'hFFF);
            wr(1, mv);
            rd(2, d); check("R2 masked status", d, 32'(12'hFEF & mv));
            check("R9 irq", irq, 32'(|(12'hFEF & mv)));
        end
        wr(0, 12'h000);
        rd(0, d); check("R10 raw write ignored", d, 16'hFEF);
        rd(1, d); check("R10 mask unchanged", d, 16'hFFF);
        rd(4, d);

        wr(1, 12'h004);
        rd(10, d); check("R8 level clear read returns level", d, 1);
        rd(0, d); check("R8 level survives clear read", d, 16'h004);
        check("R9 irq from level", irq, 1);
        rxf = 1'b0;
        @(negedge clk); check("R9 irq follows level", irq, 0);
        pulse(12'h014, '0);
        rd(0, d); check("R8 event on level bit ignored", d, 0);
        txe = 1'b1;
        rd(0, d); check("R8 tx_empty level", d, 16'h010);
        txe = 1'b0;

        pulse(12'h200, '0);
        @(negedge clk); ev = 12'h200; rd_en = 1'b1; addr = AW'(8 + 9);
        @(negedge clk); ev = '0; rd_en = 1'b0;
        rd(0, d); check("R5 event beats own clear", d, 16'h200);
        @(negedge clk); ev = 12'h001; rd_en = 1'b1; addr = AW'(4);
        @(negedge clk); ev = '0; rd_en = 1'b0;
        rd(0, d); check("R5 event beats clear-all", d, 16'h001);
        rd(4, d);

        acc = '0;
        for (int b = 0; b < 13; b++) begin
            if (b == 6 || b == 8) continue;
            pulse(12'h040, 13'(1 << b));
            acc |= 13'(1 << b);
            rd(3, d); check("R6 cause accumulates", d, 32'(acc));
        end
        rd(8 + 3, d);
        rd(0, d);
        rd(3, d); check("R6 cause held over other reads", d, 16'h1EBF);
        rd(8 + 6, d); check("R7 abort clear returns bit", d, 1);
        rd(3, d); check("R7 cause wiped by abort clear", d, 0);
        pulse(12'h040, 13'h1001);
        rd(4, d);
        rd(3, d); check("R7 cause wiped by clear-all", d, 0);
        rd(0, d); check("R4 raw empty after clear-all", d, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule